// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single PWM waveform and places it on any combination of four output pins, named A, B, C and D. Each pin has its own bit in a 4-bit steering mask. A pin whose bit is set carries the PWM signal, with that pin's polarity applied. A pin whose bit is clear carries its own port data bit. Steering only works when the mode qualifier selects the single-output configuration. In every other mode, all four pins carry port data.

A write strobe loads a new mask together with a sync-mode bit. With the sync bit clear, the new mask takes effect in the very next cycle, which can cut a PWM pulse short on a pin. With the sync bit set, the mask is held in a pending register. It moves into the active register in the same cycle as the period-start pulse, so pins only ever show whole PWM pulses. Every pin output is registered, so a pin follows its inputs with one clock of latency.

Pins are numbered A=bit 0, B=bit 1, C=bit 2, D=bit 3 in both the mask and the port data. One polarity bit covers pins A and C. A second polarity bit covers pins B and D.

Top module: `pwm_steer_top`

## Requirements
- R1: While reset is asserted, `pinOut` is 0000 and the active mask is 0000. After reset, with no write, every pin carries its port data.
- R2: A pin with its active mask bit set and polarity 0 outputs the `pwmIn` value sampled at the previous clock edge, provided steering is enabled.
- R3: A pin with its active mask bit clear outputs the `portData` bit sampled at the previous clock edge.
- R4: `polAC`=1 inverts the steered PWM on pins A and C. `polBD`=1 inverts it on pins B and D. Each polarity bit has no effect on the other pair.
- R5: Polarity bits never invert port data on a pin that is not steered.
- R6: Steering is enabled only when `outMode`==2'b00 and `ccpHi`==2'b11. In any other combination, all four pins carry port data whatever the mask holds.
- R7: A write with `syncIn`=0 makes `maskIn` the active mask from the next cycle onward, without waiting for a period start. It also discards any pending mask.
- R8: A write with `syncIn`=1 leaves the active mask unchanged until a cycle with `periodStart`=1. In that cycle the pending mask becomes active, and it drives the pins from the following cycle.
- R9: When several `syncIn`=1 writes occur before a period start, only the last one takes effect. A write in the same cycle as a period start waits for the next period start, while any earlier pending mask commits in that cycle.
- R10: With an all-zero active mask, all four pins carry port data even though steering is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Raw PWM waveform |
| periodStart | input | 1 | One-cycle pulse at the start of each PWM period |
| cfgWr | input | 1 | Write strobe for `maskIn` and `syncIn` |
| maskIn | input | 4 | New steering mask (bit 0 = A … bit 3 = D) |
| syncIn | input | 1 | 1 = defer the new mask to the next period start, 0 = apply it immediately |
| polAC | input | 1 | Polarity for pins A and C (1 = inverted) |
| polBD | input | 1 | Polarity for pins B and D (1 = inverted) |
| outMode | input | 2 | Output-mode field; 00 selects single-output steering |
| ccpHi | input | 2 | Upper mode qualifier bits; both must be 1 |
| portData | input | 4 | Port data shown on pins that are not steered |
| pinOut | output | 4 | Registered pin values |

## Verification
The assertions assume that `periodStart` is a one-cycle pulse. They also assume that every input changes only away from the rising clock edge, so the value sampled at an edge is the value the block acts on. The stimulus drives all inputs at the falling edge. It raises `periodStart` for single cycles only, spaced several cycles apart. It does issue writes in the same cycle as a period start and back-to-back deferred writes, because R9 depends on those cases.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadActive;    // immediate mask write
    logic loadPending;   // deferred mask write into shadow
    logic commitPending; // shadow -> active at period start
  } steerStrobe_t;

  // Polarity pair of a pin: even pins (A, C) use pair 0, odd pins (B, D) use pair 1
  function automatic int unsigned polPair(input int unsigned pinIdx);
    return pinIdx % 2;
  endfunction

endpackage

// File: rtl/pwm_steer_ctrl.sv
module pwm_steer_ctrl
  import pwm_steer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWr,
  input  logic         syncIn,
  input  logic         periodStart,
  output steerStrobe_t strobe,
  output logic         pendValid
);

  logic immWr;

  always_comb begin
    immWr                = cfgWr && !syncIn;
    strobe.loadActive    = immWr;
    strobe.loadPending   = cfgWr && syncIn;
    strobe.commitPending = !immWr && periodStart && pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else if (immWr) begin
      pendValid <= 1'b0;
    end else if (strobe.loadPending) begin
      pendValid <= 1'b1;
    end else if (strobe.commitPending) begin
      pendValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_steer_datapath.sv
module pwm_steer_datapath
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned QUAL_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  steerStrobe_t        strobe,
  input  logic [NUM_PINS-1:0] maskIn,
  input  logic                pwmIn,
  input  logic                polAC,
  input  logic                polBD,
  input  logic [MODE_W-1:0]   outMode,
  input  logic [QUAL_W-1:0]   ccpHi,
  input  logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] activeMask,
  output logic [NUM_PINS-1:0] pendingMask,
  output logic [NUM_PINS-1:0] pinOut
);

  localparam logic [MODE_W-1:0] SINGLE_MODE = '0;
  localparam logic [QUAL_W-1:0] QUAL_ON     = '1;

  logic                steerOn;
  logic [1:0]          polVec;
  logic [NUM_PINS-1:0] nextPin;

  assign steerOn = (outMode == SINGLE_MODE) && (ccpHi == QUAL_ON);
  assign polVec  = {polBD, polAC};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMask <= '0;
    end else if (strobe.loadActive) begin
      activeMask <= maskIn;
    end else if (strobe.commitPending) begin
      activeMask <= pendingMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingMask <= '0;
    end else if (strobe.loadPending) begin
      pendingMask <= maskIn;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic steerVal;
    assign steerVal   = pwmIn ^ polVec[polPair(i)];
    assign nextPin[i] = (steerOn && activeMask[i]) ? steerVal : portData[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut <= '0;
    end else begin
      pinOut <= nextPin;
    end
  end

endmodule

// File: rtl/pwm_steer_top.sv
module pwm_steer_top
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned QUAL_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwmIn,
  input  logic                periodStart,
  input  logic                cfgWr,
  input  logic [NUM_PINS-1:0] maskIn,
  input  logic                syncIn,
  input  logic                polAC,
  input  logic                polBD,
  input  logic [MODE_W-1:0]   outMode,
  input  logic [QUAL_W-1:0]   ccpHi,
  input  logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pinOut
);

  steerStrobe_t        strobe;
  logic                pendValid;
  logic [NUM_PINS-1:0] activeMask;
  logic [NUM_PINS-1:0] pendingMask;

  pwm_steer_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .syncIn      (syncIn),
    .periodStart (periodStart),
    .strobe      (strobe),
    .pendValid   (pendValid)
  );

  pwm_steer_datapath #(
    .NUM_PINS (NUM_PINS),
    .MODE_W   (MODE_W),
    .QUAL_W   (QUAL_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .maskIn      (maskIn),
    .pwmIn       (pwmIn),
    .polAC       (polAC),
    .polBD       (polBD),
    .outMode     (outMode),
    .ccpHi       (ccpHi),
    .portData    (portData),
    .activeMask  (activeMask),
    .pendingMask (pendingMask),
    .pinOut      (pinOut)
  );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned MODE_W   = 2,
  parameter int unsigned QUAL_W   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                pwmIn,
  input logic                periodStart,
  input logic                cfgWr,
  input logic [NUM_PINS-1:0] maskIn,
  input logic                syncIn,
  input logic                polAC,
  input logic                polBD,
  input logic [MODE_W-1:0]   outMode,
  input logic [QUAL_W-1:0]   ccpHi,
  input logic [NUM_PINS-1:0] portData,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] activeMask,
  input logic [NUM_PINS-1:0] pendingMask,
  input logic                pendValid
);

  logic enOn;
  logic immWr;
  assign enOn  = (outMode == '0) && (ccpHi == '1);
  assign immWr = cfgWr && !syncIn;

  // R1: reset clears pins and mask
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (pinOut == '0) && (activeMask == '0));

  // R2: steered pin A with polarity 0 follows pwm one cycle later
  assert_steer_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enOn && activeMask[0] && !polAC) |=> pinOut[0] == $past(pwmIn));

  // R4: steered pin B with polarity 1 shows inverted pwm
  assert_steer_invert_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enOn && activeMask[1] && polBD) |=> pinOut[1] == !$past(pwmIn));

  // R5: unsteered pin B shows port data regardless of polarity
  assert_port_plain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enOn && !activeMask[1]) |=> pinOut[1] == $past(portData[1]));

  // R6: disabled steering shows port data on all pins
  assert_disabled_port_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enOn |=> pinOut == $past(portData));

  // R7: immediate write lands in the active mask and drops pending
  assert_imm_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    immWr |=> (activeMask == $past(maskIn)) && !pendValid);

  // R8: active mask holds unless an immediate write or a period start occurs
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!immWr && !periodStart) |=> $stable(activeMask));

  // R9: pending mask commits at the period start
  assert_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!immWr && periodStart && pendValid) |=> activeMask == $past(pendingMask));

endmodule

bind pwm_steer_top pwm_steer_chk #(
  .NUM_PINS (NUM_PINS),
  .MODE_W   (MODE_W),
  .QUAL_W   (QUAL_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .pwmIn       (pwmIn),
  .periodStart (periodStart),
  .cfgWr       (cfgWr),
  .maskIn      (maskIn),
  .syncIn      (syncIn),
  .polAC       (polAC),
  .polBD       (polBD),
  .outMode     (outMode),
  .ccpHi       (ccpHi),
  .portData    (portData),
  .pinOut      (pinOut),
  .activeMask  (activeMask),
  .pendingMask (pendingMask),
  .pendValid   (pendValid)
);

// File: tb/pwm_steer_top_tb_top.sv
module pwm_steer_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwmIn = 1'b0;
  logic       periodStart = 1'b0;
  logic       cfgWr = 1'b0;
  logic [3:0] maskIn = 4'h0;
  logic       syncIn = 1'b0;
  logic       polAC = 1'b0;
  logic       polBD = 1'b0;
  logic [1:0] outMode = 2'b00;
  logic [1:0] ccpHi = 2'b11;
  logic [3:0] portData = 4'h0;
  logic [3:0] pinOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [3:0] refActive = 4'h0;
  logic [3:0] refPending = 4'h0;
  bit         refPendValid = 0;

  logic [3:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk; // 125 MHz

  pwm_steer_top dut_i (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .periodStart(periodStart),
    .cfgWr(cfgWr), .maskIn(maskIn), .syncIn(syncIn), .polAC(polAC),
    .polBD(polBD), .outMode(outMode), .ccpHi(ccpHi), .portData(portData),
    .pinOut(pinOut)
  );

  function automatic logic [3:0] expectPins();
    logic [3:0] r;
    bit en = (outMode == 2'b00) && (ccpHi == 2'b11);
    for (int i = 0; i < 4; i++) begin
      logic pol = (i % 2 == 0) ? polAC : polBD;
      r[i] = (en && refActive[i]) ? (pwmIn ^ pol) : portData[i];
    end
    return r;
  endfunction

  // Driver: inputs already set at the falling edge; push expectation and advance model
  task automatic tick(input string tag);
    expQ.push_back(expectPins());
    tagQ.push_back(tag);
    if (cfgWr && !syncIn) begin
      refActive = maskIn;
      refPendValid = 0;
    end else begin
      if (periodStart && refPendValid) begin
        refActive = refPending;
        refPendValid = 0;
      end
      if (cfgWr && syncIn) begin
        refPending = maskIn;
        refPendValid = 1;
      end
    end
    @(negedge clk);
    cfgWr = 0;
    periodStart = 0;
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (pinOut !== e) begin
        errors++;
        $display("FAIL %s: pinOut=%b expected=%b", t, pinOut, e);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    // R1: pins and mask zero during reset
    portData = 4'b1010;
    @(posedge clk); #2;
    checks++;
    if (pinOut !== 4'b0000) begin
      errors++;
      $display("FAIL R1: pinOut=%b expected=0000", pinOut);
    end
    @(negedge clk);
    rstN = 1;
    // R1 / R10: after reset every pin shows port data
    tick("R1"); portData = 4'b0101; pwmIn = 1; tick("R10");

    // R7 / R2: immediate steering to A and C
    cfgWr = 1; syncIn = 0; maskIn = 4'b0101; tick("R7");
    for (int k = 0; k < 6; k++) begin
      pwmIn = k[0]; portData = 4'(k * 3); tick("R2");
    end
    // R4: invert A,C only, then B,D only
    polAC = 1; pwmIn = 1; tick("R4"); pwmIn = 0; tick("R4");
    cfgWr = 1; maskIn = 4'b1111; tick("R7");
    polAC = 0; polBD = 1; pwmIn = 1; tick("R4"); pwmIn = 0; tick("R4");
    // R5: polarity does not touch port data
    cfgWr = 1; maskIn = 4'b0000; polAC = 1; polBD = 1; tick("R7");
    portData = 4'b1100; tick("R5"); portData = 4'b0011; tick("R5");
    polAC = 0; polBD = 0;

    // R6: other modes show port data despite a full mask
    cfgWr = 1; maskIn = 4'b1111; tick("R7");
    outMode = 2'b01; pwmIn = 1; portData = 4'b0110; tick("R6");
    outMode = 2'b00; ccpHi = 2'b10; tick("R6");
    ccpHi = 2'b01; pwmIn = 0; tick("R6");
    ccpHi = 2'b11; tick("R2");

    // R8: deferred write holds until the period start
    cfgWr = 1; syncIn = 1; maskIn = 4'b0010; portData = 4'b0000; tick("R8");
    for (int k = 0; k < 5; k++) begin pwmIn = ~pwmIn; tick("R8"); end
    periodStart = 1; tick("R8");
    for (int k = 0; k < 3; k++) begin pwmIn = ~pwmIn; tick("R8"); end

    // R9: last of several deferred writes wins
    cfgWr = 1; maskIn = 4'b0001; tick("R9");
    cfgWr = 1; maskIn = 4'b1000; tick("R9");
    pwmIn = 1; tick("R9");
    periodStart = 1; tick("R9");
    tick("R9"); pwmIn = 0; tick("R9");
    // R9: write coinciding with a period start waits for the next one
    cfgWr = 1; maskIn = 4'b0100; tick("R9");
    cfgWr = 1; maskIn = 4'b0010; periodStart = 1; pwmIn = 1; tick("R9");
    tick("R9"); tick("R9");
    periodStart = 1; tick("R9");
    tick("R9"); pwmIn = 0; tick("R9");

    // R7: immediate write discards a pending mask
    cfgWr = 1; syncIn = 1; maskIn = 4'b1111; tick("R7");
    cfgWr = 1; syncIn = 0; maskIn = 4'b0001; tick("R7");
    pwmIn = 1; periodStart = 1; tick("R7");
    tick("R7"); tick("R7");

    // R10: zero mask applied immediately, pins show port data
    cfgWr = 1; maskIn = 4'b0000; tick("R10");
    portData = 4'b1001; pwmIn = 1; tick("R10"); tick("R10");

    // R3: unsteered pins on a partial mask
    cfgWr = 1; maskIn = 4'b0110; tick("R3");
    for (int k = 0; k < 4; k++) begin
      portData = 4'(k * 5); pwmIn = k[1]; tick("R3");
    end

    @(negedge clk); @(negedge clk);
    finishRun();
  end

endmodule